// File: doc/BRIEF.md
# Display DMA Slot Arbiter

This block decides, for every horizontal bus slot of a scanline, which DMA channel drives the shared memory bus. The horizontal beam position is measured in fine-pixel units. Fixed stretches of the line are reserved for memory refresh, disk transfers, audio and eight sprite channels. A programmable bitplane fetch window overlays that map. The window is set by a start register and a stop register, and it moves in bursts whose size depends on the bus-width mode and the pixel resolution. Where the window overlaps a reserved stretch, bitplane fetch takes the slot. An early window therefore takes the sprite slots first, and then the audio, disk and refresh slots ahead of them.

The block also raises a pixel-valid flag for the span of positions where fetched pixels leave the output pipeline. That span is shifted by a fixed pipeline gap plus a prefetch amount. Both outputs are registered. Each grant is therefore valid one clock after the beam position that it answers.

Top module: `dma_slot_arbiter`

## Requirements
- R1: At most one bit of `grant` is set in any cycle. The bits are: bit 0 refresh, bit 1 disk, bit 2 audio, bits 3 to 10 sprites 0 to 7, bit 11 bitplane.
- R2: Outside the fetch window, the slot owner is fixed by position. Positions 0 to 47 belong to refresh, 48 to 95 to disk and 96 to 159 to audio. Sprite k owns positions 160+32k to 191+32k for k from 0 to 7, so the sprite stretch ends at 416.
- R3: The fetch start position is `fetch_start`×8 rounded down to the alignment A = 16·2^(w+r). Here w is `bus_width` (0 = 1x, 1 = 2x, 2 or 3 = 4x) and r is `pix_res` (0 = finest, 1 = middle, 2 or 3 = coarsest). The fetch unit U is the larger of 64 and A. The window covers positions from the aligned start up to, but not including, `fetch_stop`×8+U.
- R4: Inside the window, with the bitplane enable set, bitplane fetch wins the slot over the fixed owner. This applies to refresh, disk, audio and sprite slots, and to positions that have no fixed owner.
- R5: A channel whose enable is low is never granted. If a fixed owner is disabled, its slot stays idle even inside the window. If bitplane is disabled, the fixed owners keep their slots.
- R6: When `fetch_stop` is less than `fetch_start`, there is no fetch window and `pix_valid` stays low.
- R7: `pix_valid` is high for positions from aligned start + 4 + P up to, but not including, window end + 4 + P, where P is the smaller of 64 and A.
- R8: Both outputs are registered. The values seen after a clock edge answer the inputs present at that edge. Synchronous reset clears `grant` and `pix_valid`.
- R9: A position at 416 or above that lies outside the window grants nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hpos | input | 11 | Horizontal beam position in fine pixels |
| fetch_start | input | 8 | Fetch window start, position divided by 8 |
| fetch_stop | input | 8 | Last fetch burst start, position divided by 8 |
| bus_width | input | 2 | Bus-width mode: 0 = 1x, 1 = 2x, 2 or 3 = 4x |
| pix_res | input | 2 | Pixel resolution: 0 = finest, 1 = middle, 2 or 3 = coarsest |
| chan_en | input | 12 | Per-channel enables, in the same bit order as grant |
| grant | output | 12 | One-hot slot grant, zero when the slot is idle |
| pix_valid | output | 1 | Pixel output phase of the fetch window |

## Verification
The bench checks the edges of the slot boundaries: 47/48, 159/160, 191/192 and 415/416. An off-by-one there would hand a slot to a neighbouring channel. It uses unaligned start values at every combination of width and resolution. A design that skipped the round-down, or that picked the wrong fetch unit, would open or close the fetch window one burst early or late, and would misplace the pixel-valid span by the same amount. It also drives a window over a disabled fixed owner. A design that let bitplane fetch fill that slot would grant bit 11 where the slot must stay idle. Finally, it drives reversed start and stop values, where any grant to bitplane or any pixel-valid is an error.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  // Bit positions of the fixed channels in the grant vector
  localparam int REFRESH_IDX  = 0;
  localparam int DISK_IDX     = 1;
  localparam int AUDIO_IDX    = 2;
  localparam int SPR_BASE_IDX = 3;

  // Width-mode and resolution codes 3 behave like code 2
  function automatic logic [2:0] fetch_shift(input logic [1:0] width_mode,
                                             input logic [1:0] res_mode);
    logic [2:0] w;
    logic [2:0] r;
    w = (width_mode == 2'd3) ? 3'd2 : {1'b0, width_mode};
    r = (res_mode == 2'd3) ? 3'd2 : {1'b0, res_mode};
    return w + r;
  endfunction

endpackage

// File: rtl/dma_slot_map.sv
module dma_slot_map
  import dma_arb_pkg::*;
#(
  parameter int HPOS_W      = 11,
  parameter int NUM_SPR     = 8,
  parameter int REFRESH_END = 48,
  parameter int DISK_END    = 96,
  parameter int AUDIO_END   = 160,
  parameter int SPR_SLOT    = 32,
  localparam int NFIX       = SPR_BASE_IDX + NUM_SPR
) (
  input  logic [HPOS_W-1:0] hpos,
  output logic [NFIX-1:0]   fixed_owner
);

  localparam logic [HPOS_W-1:0] REF_LIM = HPOS_W'(REFRESH_END);
  localparam logic [HPOS_W-1:0] DSK_LIM = HPOS_W'(DISK_END);
  localparam logic [HPOS_W-1:0] AUD_LIM = HPOS_W'(AUDIO_END);

  assign fixed_owner[REFRESH_IDX] = (hpos < REF_LIM);
  assign fixed_owner[DISK_IDX]    = (hpos >= REF_LIM) && (hpos < DSK_LIM);
  assign fixed_owner[AUDIO_IDX]   = (hpos >= DSK_LIM) && (hpos < AUD_LIM);

  for (genvar k = 0; k < NUM_SPR; k++) begin : g_spr
    localparam logic [HPOS_W-1:0] LO = HPOS_W'(AUDIO_END + k * SPR_SLOT);
    localparam logic [HPOS_W-1:0] HI = HPOS_W'(AUDIO_END + (k + 1) * SPR_SLOT);
    assign fixed_owner[SPR_BASE_IDX + k] = (hpos >= LO) && (hpos < HI);
  end

endmodule

// File: rtl/dma_fetch_window.sv
module dma_fetch_window
  import dma_arb_pkg::*;
#(
  parameter int HPOS_W       = 11,
  parameter int START_W      = 8,
  parameter int BASE_ALIGN   = 16,
  parameter int MIN_UNIT     = 64,
  parameter int PREFETCH_MAX = 64,
  parameter int PIPE_GAP     = 4,
  localparam int CW          = HPOS_W + 2
) (
  input  logic [HPOS_W-1:0]  hpos,
  input  logic [START_W-1:0] start_reg,
  input  logic [START_W-1:0] stop_reg,
  input  logic [1:0]         width_mode,
  input  logic [1:0]         res_mode,
  output logic               in_fetch,
  output logic               in_pixel
);

  localparam logic [CW-1:0] BASE_A  = CW'(BASE_ALIGN);
  localparam logic [CW-1:0] UNIT_LO = CW'(MIN_UNIT);
  localparam logic [CW-1:0] PRE_HI  = CW'(PREFETCH_MAX);
  localparam logic [CW-1:0] GAP     = CW'(PIPE_GAP);

  logic [CW-1:0] align, unit, pre, start_pos, aligned, stop_pos;
  logic [CW-1:0] win_end, pix_start, pix_end, h;
  logic          win_ok;

  always_comb begin
    align     = BASE_A << fetch_shift(width_mode, res_mode);
    unit      = (align < UNIT_LO) ? UNIT_LO : align;
    pre       = (align > PRE_HI) ? PRE_HI : align;
    start_pos = CW'({start_reg, 3'b000});
    stop_pos  = CW'({stop_reg, 3'b000});
    aligned   = start_pos & ~(align - CW'(1));
    win_end   = stop_pos + unit;
    pix_start = aligned + GAP + pre;
    pix_end   = win_end + GAP + pre;
    h         = CW'(hpos);
    win_ok    = (stop_reg >= start_reg);
    in_fetch  = win_ok && (h >= aligned) && (h < win_end);
    in_pixel  = win_ok && (h >= pix_start) && (h < pix_end);
  end

endmodule

// File: rtl/dma_slot_arbiter.sv
module dma_slot_arbiter
  import dma_arb_pkg::*;
#(
  parameter int HPOS_W  = 11,
  parameter int START_W = 8,
  parameter int NUM_SPR = 8,
  localparam int NFIX   = SPR_BASE_IDX + NUM_SPR,
  localparam int NCH    = NFIX + 1,
  localparam int BP_IDX = NFIX
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [HPOS_W-1:0]  hpos,
  input  logic [START_W-1:0] fetch_start,
  input  logic [START_W-1:0] fetch_stop,
  input  logic [1:0]         bus_width,
  input  logic [1:0]         pix_res,
  input  logic [NCH-1:0]     chan_en,
  output logic [NCH-1:0]     grant,
  output logic               pix_valid
);

  logic [NFIX-1:0] fixed_owner, fixed_live;
  logic            in_fetch, in_pixel;
  logic [NCH-1:0]  grant_d;

  dma_slot_map #(.HPOS_W(HPOS_W), .NUM_SPR(NUM_SPR)) u_map (
    .hpos        (hpos),
    .fixed_owner (fixed_owner)
  );

  dma_fetch_window #(.HPOS_W(HPOS_W), .START_W(START_W)) u_win (
    .hpos       (hpos),
    .start_reg  (fetch_start),
    .stop_reg   (fetch_stop),
    .width_mode (bus_width),
    .res_mode   (pix_res),
    .in_fetch   (in_fetch),
    .in_pixel   (in_pixel)
  );

  always_comb begin
    fixed_live = fixed_owner & chan_en[NFIX-1:0];
    grant_d    = '0;
    if (in_fetch && chan_en[BP_IDX]) begin
      // a disabled fixed owner keeps its slot idle
      if (fixed_owner == '0 || fixed_live != '0) grant_d[BP_IDX] = 1'b1;
    end else begin
      grant_d[NFIX-1:0] = fixed_live;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant     <= '0;
      pix_valid <= 1'b0;
    end else begin
      grant     <= grant_d;
      pix_valid <= in_pixel;
    end
  end

endmodule

// File: rtl/dma_slot_arbiter_chk.sv
module dma_slot_arbiter_chk #(
  parameter int HPOS_W  = 11,
  parameter int START_W = 8,
  parameter int NCH     = 12,
  parameter int SPR_END = 416
) (
  input logic               clk,
  input logic               rst,
  input logic [HPOS_W-1:0]  hpos,
  input logic [START_W-1:0] fetch_start,
  input logic [START_W-1:0] fetch_stop,
  input logic [NCH-1:0]     chan_en,
  input logic [NCH-1:0]     grant,
  input logic               pix_valid
);

  localparam logic [HPOS_W-1:0] SPR_LIM = HPOS_W'(SPR_END);
  localparam logic [HPOS_W-1:0] REF_LIM = HPOS_W'(48);

  assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  assert_disabled_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((grant & ~$past(chan_en)) == '0));

  assert_empty_window_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fetch_stop) < $past(fetch_start))
      |-> (!grant[NCH-1] && !pix_valid));

  assert_beyond_sprites_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && grant != '0 && !grant[NCH-1]) |-> ($past(hpos) < SPR_LIM));

  assert_refresh_zone_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(hpos) < REF_LIM && grant != '0)
      |-> (grant[0] || grant[NCH-1]));

endmodule

bind dma_slot_arbiter dma_slot_arbiter_chk #(
  .HPOS_W(HPOS_W), .START_W(START_W), .NCH(NCH)
) u_chk (
  .clk(clk), .rst(rst), .hpos(hpos), .fetch_start(fetch_start),
  .fetch_stop(fetch_stop), .chan_en(chan_en), .grant(grant),
  .pix_valid(pix_valid)
);

// File: tb/dma_slot_arbiter_test.sv
`timescale 1ns/1ps
module dma_slot_arbiter_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] hpos = '0;
  logic [7:0]  fetch_start = '0;
  logic [7:0]  fetch_stop = '0;
  logic [1:0]  bus_width = '0;
  logic [1:0]  pix_res = '0;
  logic [11:0] chan_en = '1;
  logic [11:0] grant;
  logic        pix_valid;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dma_slot_arbiter uut (
    .clk(clk), .rst(rst), .hpos(hpos), .fetch_start(fetch_start),
    .fetch_stop(fetch_stop), .bus_width(bus_width), .pix_res(pix_res),
    .chan_en(chan_en), .grant(grant), .pix_valid(pix_valid)
  );

  // Reference model, written from the requirements
  function automatic int align_of(int w, int r);
    int wc = (w > 2) ? 2 : w;
    int rc = (r > 2) ? 2 : r;
    return 16 << (wc + rc);
  endfunction

  function automatic int owner_of(int h);
    if (h < 48) return 0;
    if (h < 96) return 1;
    if (h < 160) return 2;
    if (h < 416) return 3 + (h - 160) / 32;
    return -1;
  endfunction

  int exp_g_i;
  bit exp_pix;
  string exp_tag;

  task automatic model(input int h, input int st, input int sp, input int w,
                       input int r, input logic [11:0] en);
    int a = align_of(w, r);
    int u = (a < 64) ? 64 : a;
    int p = (a > 64) ? 64 : a;
    int s = (st * 8) - ((st * 8) % a);
    int e = sp * 8 + u;
    bit ok = (sp >= st);
    bit inw = ok && h >= s && h < e;
    int own = owner_of(h);
    exp_pix = ok && h >= s + 4 + p && h < e + 4 + p;
    exp_g_i = -1;
    if (!ok) exp_tag = "R6";
    else if (inw) exp_tag = "R4";
    else if (own < 0) exp_tag = "R9";
    else exp_tag = "R2";
    if (inw && en[11]) begin
      if (own < 0 || en[own]) exp_g_i = 11;
      else exp_tag = "R5";
    end else if (own >= 0) begin
      if (en[own]) exp_g_i = own;
      else exp_tag = "R5";
    end
  endtask

  task automatic check(input string tag, input bit cond, input int act, input int exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h hpos=%0d", tag, act, exp, hpos);
    end
  endtask

  // apply inputs, let one edge capture them, compare at the next falling edge
  task automatic step(input int h, input int st, input int sp, input int w,
                      input int r, input logic [11:0] en);
    logic [11:0] eg;
    hpos = 11'(h); fetch_start = 8'(st); fetch_stop = 8'(sp);
    bus_width = 2'(w); pix_res = 2'(r); chan_en = en;
    model(h, st, sp, w, r, en);
    eg = (exp_g_i < 0) ? 12'h000 : (12'h001 << exp_g_i);
    @(negedge clk);
    check(exp_tag, grant == eg, grant, eg);
    check("R7", pix_valid == exp_pix, pix_valid, exp_pix);
    check("R1", $countones(grant) <= 1, grant, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset", grant == 0 && pix_valid == 0, {grant, pix_valid}, 0);
    rst = 1'b0;
    // R2 boundaries with window far right
    foreach (int_list[i]) step(int_list[i], 250, 254, 0, 0, 12'hFFF);
    // R3 unaligned starts in every width/resolution combination
    for (int w = 0; w < 4; w++)
      for (int r = 0; r < 4; r++)
        for (int h = 0; h < 900; h += 7) step(h, 27, 60, w, r, 12'hFFF);
    // R4 early window steals refresh, disk, audio and sprite slots
    for (int h = 0; h < 700; h += 3) step(h, 2, 40, 2, 0, 12'hFFF);
    // R5 disabled owners inside the window stay idle, bitplane off keeps owners
    for (int h = 0; h < 600; h += 5) step(h, 4, 50, 1, 1, 12'hA5B);
    for (int h = 0; h < 600; h += 5) step(h, 4, 50, 1, 1, 12'h7FF);
    // R6 reversed window
    for (int h = 0; h < 2048; h += 11) step(h, 60, 20, 2, 2, 12'hFFF);
    // R8 latency: rapidly changing position
    step(10, 100, 120, 0, 0, 12'hFFF);
    step(170, 100, 120, 0, 0, 12'hFFF);
    step(900, 100, 120, 0, 0, 12'hFFF);
    check("R8 latency", grant == 12'h800, grant, 12'h800);
    // random mix, fixed seed
    void'($urandom(32'h5EED));
    for (int i = 0; i < 4000; i++) begin
      int st = $urandom_range(0, 254) & 8'hFE;
      int sp = ($urandom_range(0, 9) == 0) ? ($urandom_range(0, 254) & 8'hFE)
               : (st + 8 * $urandom_range(0, 12) > 254 ? 254 : st + 8 * $urandom_range(0, 12));
      logic [11:0] en = ($urandom_range(0, 3) == 0) ? 12'($urandom()) : 12'hFFF;
      step($urandom_range(0, 2047), st, sp, $urandom_range(0, 3),
           $urandom_range(0, 3), en);
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  int int_list[12] = '{0, 47, 48, 95, 96, 159, 160, 191, 192, 415, 416, 2047};

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule